// File: doc/BRIEF.md
# Measured-Launch Locality Gatekeeper

This block stands between a register bus and a bank of platform measurement registers. Every bus request carries a locality number from 0 to 4. The block decides from the locality, the register index and the current launch state whether the request is honoured. It runs a hash session that only the most privileged locality can drive, and it keeps the register bank inside. Each register is updated by a one-way fold of its old value and a new word. The hash engine sits outside the block. The block sends it start, data and end strobes, and it takes the finished digest back on a valid/ready input.

A sticky error-code register can be written only by locality 4. While it holds a nonzero value, no launch can complete, and an attempt to launch pulses a platform-reset request instead. When the session finishes, the block folds the digest into dynamic register 17 and enters the launched state. In that state locality 2 may extend registers 17 to 22. An exit command moves the block to the exited state and takes those rights away again. A new launch can then start without a platform reset.

Bus requests use valid/ready. The block drops `req_ready` only while it waits for the digest, and the requester must hold its request stable until it is accepted. Each accepted request gets exactly one response, one cycle later. The response has no back-pressure.

Top module: `launch_gate`

## Requirements
- R1: After reset, registers 17 to 22 read all-ones, every other register reads zero, `launch_state` is 0 (idle), `seq_err` is 0, `req_ready` is 1 and `dig_ready` is 0.
- R2: Opcode 2 writes the error code and succeeds only from locality 4. From any other locality it gets an error response and the code is unchanged. Opcode 7 reads the code from any locality.
- R3: Opcode 3 (hash start) from locality 4 while the error code is nonzero gets an error response and a one-cycle `plat_rst` pulse together with that response, and the state does not change. The same applies if a digest arrives while the code is nonzero: the block then returns to idle, pulses `plat_rst` and leaves register 17 unchanged.
- R4: Opcodes 3, 4 and 5 (hash start, data, end) from any locality other than 4 get an error response and have no effect.
- R5: An accepted hash start clears registers 17 to 22 to zero and enters state 1 (hashing). Opcode 4 forwards its data word on `hs_word` with a one-cycle `hs_data` pulse. Opcode 5 pulses `hs_end` and enters state 2 (waiting). There `dig_ready` is 1, and an accepted digest is folded into register 17, after which the state is 3 (launched).
- R6: A fold computes new = (old rotated left by one bit) XOR word.
- R7: Opcode 1 (extend) to registers 17 to 22 succeeds only from locality 2 in state 3.
- R8: Extend to registers 0 to 7 succeeds only from locality 0 in state 0 or 4. A hash session never changes these registers.
- R9: Opcode 6 from locality 2 in state 3 enters state 4 (exited). After that, locality 2 extends are refused and a new hash start from state 4 is accepted.
- R10: Hash data or hash end from locality 4 outside state 1 gets an error response and is dropped, and the `seq_err` flag is set and stays set.
- R11: A refused request gets an error response and changes neither the registers, the error code nor the state. Opcode 0 reads the register at `req_idx`, and an index of 24 or more is refused.
- R12: `req_ready` is 0 exactly in state 2. The response to a request accepted at a clock edge appears at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low platform reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_loc | input | 3 | Locality of the request |
| req_op | input | 3 | Opcode |
| req_idx | input | 5 | Register index |
| req_data | input | 32 | Write or extend word |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_err | output | 1 | Request was refused |
| rsp_data | output | 32 | Read data |
| hs_start_o | output | 1 | Hash start strobe |
| hs_data_o | output | 1 | Hash data strobe |
| hs_word_o | output | 32 | Word for the hash engine |
| hs_end_o | output | 1 | Hash end strobe |
| dig_valid_i | input | 1 | Digest valid |
| dig_ready_o | output | 1 | Digest can be accepted |
| dig_i | input | 32 | Digest value |
| plat_rst_o | output | 1 | Platform reset request pulse |
| seq_err_o | output | 1 | Sticky out-of-sequence flag |
| launch_state_o | output | 3 | Launch state code |

## Verification
A wrong launch state shows up at once at the ports: the next request gets the wrong refusal, locality 2 gains or loses extend rights, or `req_ready` stays low. Every response also reports `launch_state`, so a bad state code can be seen one cycle after the request that caused it. A corrupted register or a lost clear shows up as a wrong value at the next read. The reads are placed straight after each extend, hash start and digest. A skipped veto shows up as a missing `plat_rst` pulse in the response cycle, or as state 3 being reached while the error code is nonzero.

// File: rtl/lg_pkg.sv
package lg_pkg;
  typedef enum logic [2:0] {
    OP_RD     = 3'd0,
    OP_EXT    = 3'd1,
    OP_ERRW   = 3'd2,
    OP_HSTART = 3'd3,
    OP_HDATA  = 3'd4,
    OP_HEND   = 3'd5,
    OP_EXIT   = 3'd6,
    OP_ERRRD  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HASH = 3'd1,
    ST_WAIT = 3'd2,
    ST_LIVE = 3'd3,
    ST_EXIT = 3'd4
  } st_e;

  typedef struct packed {
    logic allow;
    logic ext;
    logic errw;
    logic hstart;
    logic hdata;
    logic hend;
    logic leave;
    logic veto;
    logic seq_bad;
  } verdict_t;
endpackage

// File: rtl/lg_access.sv
module lg_access
  import lg_pkg::*;
#(
  parameter int IW       = 5,
  parameter int NREG     = 24,
  parameter int DYN_LO   = 17,
  parameter int DYN_HI   = 22,
  parameter int STAT_HI  = 7,
  parameter int PRIV_LOC = 4,
  parameter int OS_LOC   = 2,
  parameter int FW_LOC   = 0
) (
  input  op_e             op,
  input  logic [2:0]      loc,
  input  logic [IW-1:0]   idx,
  input  st_e             st,
  input  logic            err_nz,
  output verdict_t        v
);
  localparam logic [IW:0] NREG_I    = (IW+1)'(NREG);
  localparam logic [IW:0] DYN_LO_I  = (IW+1)'(DYN_LO);
  localparam logic [IW:0] DYN_HI_I  = (IW+1)'(DYN_HI);
  localparam logic [IW:0] STAT_HI_I = (IW+1)'(STAT_HI);
  localparam logic [2:0]  PRIV_L    = 3'(PRIV_LOC);
  localparam logic [2:0]  OS_L      = 3'(OS_LOC);
  localparam logic [2:0]  FW_L      = 3'(FW_LOC);

  logic [IW:0] idx_w;
  logic        pre_launch, in_static, in_dyn, in_range;

  assign idx_w      = {1'b0, idx};
  assign pre_launch = (st == ST_IDLE) || (st == ST_EXIT);
  assign in_static  = idx_w <= STAT_HI_I;
  assign in_dyn     = (idx_w >= DYN_LO_I) && (idx_w <= DYN_HI_I);
  assign in_range   = idx_w < NREG_I;

  always_comb begin
    v = '0;
    unique case (op)
      OP_RD:    v.allow = in_range;
      OP_ERRRD: v.allow = 1'b1;
      OP_EXT: begin
        if (in_static && loc == FW_L && pre_launch) begin
          v.allow = 1'b1;
          v.ext   = 1'b1;
        end else if (in_dyn && loc == OS_L && st == ST_LIVE) begin
          v.allow = 1'b1;
          v.ext   = 1'b1;
        end
      end
      OP_ERRW: begin
        v.allow = (loc == PRIV_L);
        v.errw  = (loc == PRIV_L);
      end
      OP_HSTART: begin
        if (loc == PRIV_L && pre_launch) begin
          v.veto   = err_nz;
          v.allow  = !err_nz;
          v.hstart = !err_nz;
        end
      end
      OP_HDATA: begin
        if (loc == PRIV_L) begin
          v.allow   = (st == ST_HASH);
          v.hdata   = (st == ST_HASH);
          v.seq_bad = (st != ST_HASH);
        end
      end
      OP_HEND: begin
        if (loc == PRIV_L) begin
          v.allow   = (st == ST_HASH);
          v.hend    = (st == ST_HASH);
          v.seq_bad = (st != ST_HASH);
        end
      end
      OP_EXIT: begin
        v.allow = (loc == OS_L) && (st == ST_LIVE);
        v.leave = (loc == OS_L) && (st == ST_LIVE);
      end
      default: v = '0;
    endcase
  end
endmodule

// File: rtl/lg_bank.sv
module lg_bank #(
  parameter int DW     = 32,
  parameter int NREG   = 24,
  parameter int IW     = 5,
  parameter int DYN_LO = 17,
  parameter int DYN_HI = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_en,
  input  logic [IW-1:0] ext_idx,
  input  logic [DW-1:0] ext_val,
  input  logic          dyn_clr,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_DYN = (i >= DYN_LO) && (i <= DYN_HI);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= IS_DYN ? '1 : '0;
      else if (dyn_clr && IS_DYN)
        q <= '0;
      else if (ext_en && ext_idx == IW'(i))
        q <= {q[DW-2:0], q[DW-1]} ^ ext_val;
    end
    assign regs[i] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_idx == IW'(k)) rd_data = regs[k];
  end
endmodule

// File: rtl/launch_gate.sv
module launch_gate
  import lg_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NREG     = 24,
  parameter int EW       = 8,
  parameter int DYN_LO   = 17,
  parameter int DYN_HI   = 22,
  parameter int STAT_HI  = 7,
  parameter int PRIV_LOC = 4,
  parameter int OS_LOC   = 2,
  parameter int FW_LOC   = 0,
  localparam int IW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_loc,
  input  logic [2:0]    req_op,
  input  logic [IW-1:0] req_idx,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data,
  output logic          hs_start_o,
  output logic          hs_data_o,
  output logic [DW-1:0] hs_word_o,
  output logic          hs_end_o,
  input  logic          dig_valid_i,
  output logic          dig_ready_o,
  input  logic [DW-1:0] dig_i,
  output logic          plat_rst_o,
  output logic          seq_err_o,
  output logic [2:0]    launch_state_o
);
  st_e           st_q;
  logic [EW-1:0] err_q;
  verdict_t      v;
  op_e           op;
  logic          acc, dig_fire, err_nz, bus_ext, ext_en;
  logic [IW-1:0] ext_idx;
  logic [DW-1:0] ext_val, rd_data;

  assign op             = op_e'(req_op);
  assign req_ready      = (st_q != ST_WAIT);
  assign acc            = req_valid && req_ready;
  assign dig_ready_o    = (st_q == ST_WAIT);
  assign dig_fire       = dig_valid_i && dig_ready_o;
  assign err_nz         = |err_q;
  assign launch_state_o = st_q;

  lg_access #(
    .IW(IW), .NREG(NREG), .DYN_LO(DYN_LO), .DYN_HI(DYN_HI), .STAT_HI(STAT_HI),
    .PRIV_LOC(PRIV_LOC), .OS_LOC(OS_LOC), .FW_LOC(FW_LOC)
  ) access_i (
    .op(op), .loc(req_loc), .idx(req_idx), .st(st_q), .err_nz(err_nz), .v(v)
  );

  // The bus and the digest never both extend: no bus request is accepted while waiting.
  assign bus_ext = acc && v.ext;
  assign ext_en  = bus_ext || (dig_fire && !err_nz);
  assign ext_idx = dig_fire ? IW'(DYN_LO) : req_idx;
  assign ext_val = dig_fire ? dig_i : req_data;

  lg_bank #(
    .DW(DW), .NREG(NREG), .IW(IW), .DYN_LO(DYN_LO), .DYN_HI(DYN_HI)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .ext_idx(ext_idx),
    .ext_val(ext_val), .dyn_clr(acc && v.hstart), .rd_idx(req_idx),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else if (dig_fire) begin
      st_q <= err_nz ? ST_IDLE : ST_LIVE;
    end else if (acc) begin
      if (v.hstart)     st_q <= ST_HASH;
      else if (v.hend)  st_q <= ST_WAIT;
      else if (v.leave) st_q <= ST_EXIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             err_q <= '0;
    else if (acc && v.errw) err_q <= req_data[EW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_data   <= '0;
      hs_start_o <= 1'b0;
      hs_data_o  <= 1'b0;
      hs_word_o  <= '0;
      hs_end_o   <= 1'b0;
      plat_rst_o <= 1'b0;
      seq_err_o  <= 1'b0;
    end else begin
      rsp_valid  <= acc;
      rsp_err    <= acc && !v.allow;
      if (acc && v.allow && op == OP_RD)         rsp_data <= rd_data;
      else if (acc && v.allow && op == OP_ERRRD) rsp_data <= DW'(err_q);
      else                                       rsp_data <= '0;
      hs_start_o <= acc && v.hstart;
      hs_data_o  <= acc && v.hdata;
      if (acc && v.hdata) hs_word_o <= req_data;
      hs_end_o   <= acc && v.hend;
      plat_rst_o <= (acc && v.veto) || (dig_fire && err_nz);
      seq_err_o  <= seq_err_o || (acc && v.seq_bad);
    end
  end
endmodule

// File: rtl/lg_chk.sv
module lg_chk #(
  parameter int EW     = 8,
  parameter int IW     = 5,
  parameter int DYN_LO = 17,
  parameter int DYN_HI = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc,
  input logic [2:0]    req_loc,
  input logic [2:0]    req_op,
  input logic [IW-1:0] req_idx,
  input logic [2:0]    st,
  input logic [EW-1:0] err,
  input logic          hs_start,
  input logic          req_ready,
  input logic          bus_ext
);
  // R2
  err_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 3'd2 && req_loc != 3'd4) |=> $stable(err));

  // R3
  launch_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && $past(st) != 3'd3) |-> ($past(err) == '0));

  // R4
  hash_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start |-> ($past(req_loc) == 3'd4 && $past(acc)));

  // R7
  dyn_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ext && req_idx >= IW'(DYN_LO) && req_idx <= IW'(DYN_HI)) |->
      (st == 3'd3 && req_loc == 3'd2));

  // R12
  wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2) |-> !req_ready);
endmodule

bind launch_gate lg_chk #(.EW(EW), .IW(IW), .DYN_LO(DYN_LO), .DYN_HI(DYN_HI)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc(acc), .req_loc(req_loc), .req_op(req_op),
  .req_idx(req_idx), .st(launch_state_o), .err(err_q), .hs_start(hs_start_o),
  .req_ready(req_ready), .bus_ext(bus_ext)
);

// File: tb/launch_gate_tb_top.sv
module launch_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_loc = '0, req_op = '0;
  logic [4:0]  req_idx = '0;
  logic [31:0] req_data = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_data, hs_word_o;
  logic        hs_start_o, hs_data_o, hs_end_o, dig_ready_o, plat_rst_o, seq_err_o;
  logic        dig_valid_i = 1'b0;
  logic [31:0] dig_i = 32'hA5A5_0000;
  logic [2:0]  launch_state_o;

  int nchk = 0, nfail = 0, cyc = 0, dcnt = 0;
  int n_hdata = 0, n_rst = 0;
  logic [31:0] cap_word = '0;

  always #4 clk = ~clk;

  launch_gate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_loc(req_loc), .req_op(req_op), .req_idx(req_idx), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .hs_start_o(hs_start_o), .hs_data_o(hs_data_o), .hs_word_o(hs_word_o),
    .hs_end_o(hs_end_o), .dig_valid_i(dig_valid_i), .dig_ready_o(dig_ready_o),
    .dig_i(dig_i), .plat_rst_o(plat_rst_o), .seq_err_o(seq_err_o),
    .launch_state_o(launch_state_o)
  );

  // Digest source: answers two cycles after the block starts waiting.
  always @(negedge clk) begin
    if (hs_data_o) begin n_hdata++; cap_word = hs_word_o; end
    if (plat_rst_o) n_rst++;
    if (dig_valid_i) dig_valid_i = 1'b0;
    else if (dig_ready_o) begin
      dcnt++;
      if (dcnt == 2) begin dig_valid_i = 1'b1; dcnt = 0; end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  loc;
    logic [2:0]  op;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        err;
    logic [31:0] exp;
    logic [2:0]  st;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 5'd17, 32'h0,      1'b0, 32'hFFFF_FFFF, 3'd0}, // R1 dyn reset ones
    '{3'd0, 3'd1, 5'd3,  32'h1,      1'b0, 32'h0,         3'd0}, // R8
    '{3'd0, 3'd1, 5'd3,  32'h10,     1'b0, 32'h0,         3'd0}, // R8
    '{3'd1, 3'd0, 5'd3,  32'h0,      1'b0, 32'h12,        3'd0}, // R6 fold
    '{3'd1, 3'd1, 5'd3,  32'h5,      1'b1, 32'h0,         3'd0}, // R8 wrong loc
    '{3'd0, 3'd0, 5'd3,  32'h0,      1'b0, 32'h12,        3'd0}, // R11 unchanged
    '{3'd2, 3'd1, 5'd18, 32'h1,      1'b1, 32'h0,         3'd0}, // R7 not launched
    '{3'd0, 3'd2, 5'd0,  32'h7,      1'b1, 32'h0,         3'd0}, // R2 unprivileged
    '{3'd0, 3'd7, 5'd0,  32'h0,      1'b0, 32'h0,         3'd0}, // R2 code still 0
    '{3'd4, 3'd4, 5'd0,  32'h9,      1'b1, 32'h0,         3'd0}, // R10
    '{3'd3, 3'd3, 5'd0,  32'h0,      1'b1, 32'h0,         3'd0}, // R4
    '{3'd4, 3'd2, 5'd0,  32'h5,      1'b0, 32'h0,         3'd0}, // R2
    '{3'd4, 3'd3, 5'd0,  32'h0,      1'b1, 32'h0,         3'd0}, // R3 veto
    '{3'd0, 3'd0, 5'd17, 32'h0,      1'b0, 32'hFFFF_FFFF, 3'd0}, // R3 no clear
    '{3'd4, 3'd2, 5'd0,  32'h0,      1'b0, 32'h0,         3'd0}, // R2 clear
    '{3'd4, 3'd3, 5'd0,  32'h0,      1'b0, 32'h0,         3'd1}, // R5 start
    '{3'd0, 3'd0, 5'd17, 32'h0,      1'b0, 32'h0,         3'd1}, // R5 cleared
    '{3'd4, 3'd4, 5'd0,  32'h1234,   1'b0, 32'h0,         3'd1}, // R5 data
    '{3'd4, 3'd5, 5'd0,  32'h0,      1'b0, 32'h0,         3'd2}, // R5 end
    '{3'd0, 3'd0, 5'd17, 32'h0,      1'b0, 32'hA5A5_0000, 3'd3}, // R5 digest
    '{3'd2, 3'd1, 5'd18, 32'h3,      1'b0, 32'h0,         3'd3}, // R7
    '{3'd2, 3'd1, 5'd17, 32'h1,      1'b0, 32'h0,         3'd3}, // R7
    '{3'd0, 3'd0, 5'd17, 32'h0,      1'b0, 32'h4B4A_0000, 3'd3}, // R6
    '{3'd0, 3'd0, 5'd18, 32'h0,      1'b0, 32'h3,         3'd3}, // R7
    '{3'd2, 3'd1, 5'd23, 32'h1,      1'b1, 32'h0,         3'd3}, // R7 outside dyn
    '{3'd0, 3'd1, 5'd3,  32'h1,      1'b1, 32'h0,         3'd3}, // R8 launched
    '{3'd4, 3'd3, 5'd0,  32'h0,      1'b1, 32'h0,         3'd3}, // R11 start in live
    '{3'd2, 3'd6, 5'd0,  32'h0,      1'b0, 32'h0,         3'd4}, // R9 exit
    '{3'd2, 3'd1, 5'd18, 32'h1,      1'b1, 32'h0,         3'd4}, // R9 revoked
    '{3'd0, 3'd0, 5'd18, 32'h0,      1'b0, 32'h3,         3'd4}, // R9 unchanged
    '{3'd4, 3'd3, 5'd0,  32'h0,      1'b0, 32'h0,         3'd1}, // R9 relaunch
    '{3'd0, 3'd0, 5'd18, 32'h0,      1'b0, 32'h0,         3'd1}, // R5 cleared
    '{3'd4, 3'd5, 5'd0,  32'h0,      1'b0, 32'h0,         3'd2}, // R5
    '{3'd0, 3'd0, 5'd17, 32'h0,      1'b0, 32'hA5A5_0000, 3'd3}, // R5
    '{3'd0, 3'd0, 5'd3,  32'h0,      1'b0, 32'h12,        3'd3}  // R8 untouched
  };

  task automatic send(logic [2:0] loc, logic [2:0] op, logic [4:0] idx, logic [31:0] data);
    while (!req_ready) @(negedge clk);
    req_loc = loc; req_op = op; req_idx = idx; req_data = data; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'b0, req_ready}, 32'd1);
    check("R1 state", {29'b0, launch_state_o}, 32'd0);
    check("R1 seq_err", {31'b0, seq_err_o}, 32'd0);
    check("R1 dig_ready", {31'b0, dig_ready_o}, 32'd0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].loc, VECS[i].op, VECS[i].idx, VECS[i].data);
      check($sformatf("R12 vec %0d rsp_valid", i), {31'b0, rsp_valid}, 32'd1);
      check($sformatf("R11 vec %0d err", i), {31'b0, rsp_err}, {31'b0, VECS[i].err});
      check($sformatf("R11 vec %0d state", i), {29'b0, launch_state_o}, {29'b0, VECS[i].st});
      if (VECS[i].op == 3'd0 || VECS[i].op == 3'd7)
        check($sformatf("R6 vec %0d data", i), rsp_data, VECS[i].exp);
      if (i == 12) check("R3 plat_rst pulse", {31'b0, plat_rst_o}, 32'd1);
    end

    check("R10 seq_err sticky", {31'b0, seq_err_o}, 32'd1);
    check("R5 hs data count", n_hdata, 32'd1);
    check("R5 hs word", cap_word, 32'h1234);
    check("R3 rst count", n_rst, 32'd1);

    // R3: error set during the session aborts the launch when the digest lands.
    send(3'd2, 3'd6, 5'd0, 32'h0);
    send(3'd4, 3'd3, 5'd0, 32'h0);
    check("R3 restart", {29'b0, launch_state_o}, 32'd1);
    send(3'd4, 3'd2, 5'd0, 32'h2);
    send(3'd4, 3'd5, 5'd0, 32'h0);
    check("R12 ready low while waiting", {31'b0, req_ready}, 32'd0);
    send(3'd0, 3'd0, 5'd17, 32'h0);
    check("R3 no launch state", {29'b0, launch_state_o}, 32'd0);
    check("R3 reg17 kept", rsp_data, 32'h0);
    check("R3 rst on digest", n_rst, 32'd2);
    send(3'd1, 3'd7, 5'd0, 32'h0);
    check("R2 code read", rsp_data, 32'h2);
    send(3'd0, 3'd0, 5'd24, 32'h0);
    check("R11 index range", {31'b0, rsp_err}, 32'd1);
    send(3'd4, 3'd5, 5'd0, 32'h0);
    check("R10 end outside session", {31'b0, rsp_err}, 32'd1);
    @(negedge clk);
    check("R3 single-cycle pulse", {31'b0, plat_rst_o}, 32'd0);
    summary();
  end
endmodule